// File: doc/BRIEF.md
# Dual-Channel UART Register Access Controller

This block is the host-facing register front end of a two-channel serial port. A byte-wide host bus carries a chip select, a channel select, a 3-bit address, read and write strobes and 8-bit write data. The block decodes that bus onto two identical per-channel register sets and one alternate function byte that both channels share. Each channel holds a line control byte, a two-byte baud divisor, a data byte and an interrupt enable byte. Bit 7 of a channel's line control byte switches addresses 0 and 1 from the data and interrupt enable bytes to the divisor bytes. It also makes the shared alternate function byte visible at address 2.

When bit 0 of the shared byte is set, one bus write lands in both channels at once, which halves the time needed to program two identical channels. Reads still come only from the channel picked by the channel select. Bits 2:1 of the same byte pick what each channel's active-low multifunction pin shows. The choices are that channel's OP2, baud clock or receive-ready line, which enter the block as inputs from the serial engines. When both divisor bytes are zero, two read-only locations return an identification byte and a revision byte.

Writes take effect at the rising clock edge while chip select and write are high. Read data is combinational and is valid while chip select and read are high. It is zero otherwise.

Top module: `duo_uart_regs`

## Requirements
- R1: After reset, every per-channel register and the shared alternate function byte are 0x00. Concurrent mode is therefore off and both multifunction pins follow their OP2 inputs.
- R2: With bit 0 of the shared byte clear, a write changes only the register of the channel given by `busChan` (0 = channel A, 1 = channel B).
- R3: With bit 0 of the shared byte set, one write changes the addressed register in both channels.
- R4: Reads return the register of the channel given by `busChan`, whether concurrent mode is on or off. The map is: address 3 holds line control. Address 0 holds data (bank bit clear) or the divisor low byte (bank bit set). Address 1 holds interrupt enable (bank bit clear) or the divisor high byte (bank bit set).
- R5: The shared byte sits at address 2 when the accessed channel's line control bit 7 is set. Writing it through either channel makes the same value readable through both.
- R6: During a concurrent write to address 0, 1 or 2, channel A's line control bit 7 selects the bank for both channels.
- R7: Each channel's pin `mfN[ch]` shows `op2N[ch]` for code 00, `baudN[ch]` for code 01 and `rxRdyN[ch]` for code 11, where the code is bits 2:1 of the shared byte.
- R8: Code 10 drives both multifunction pins high.
- R9: Bits 7:3 of the shared byte are ignored on write and always read as 0.
- R10: With the bank bit set and both divisor bytes of the accessed channel zero, address 4 reads 0x02 and address 5 reads 0x01. If either divisor byte is nonzero, both addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busCs | input | 1 | Chip select, active high |
| busChan | input | 1 | Channel select: 0 = A, 1 = B |
| busAddr | input | 3 | Register address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, zero when not reading |
| op2N | input | 2 | Per-channel OP2 source, active low |
| baudN | input | 2 | Per-channel baud clock source |
| rxRdyN | input | 2 | Per-channel receive-ready source, active low |
| mfN | output | 2 | Per-channel multifunction pin |

## Verification
Writes are tried in single-channel mode and in concurrent mode, each followed by reads of both channels. The readback shows whether a write leaked into the other channel or failed to reach it. A concurrent write is issued while channel A and channel B sit in different banks, with the select pointing at B. The result shows whether A's bank bit steered both channels or each channel used its own. The pin sources are driven with a different level per channel and per source, so every select code produces its own pin pattern. The identification reads are taken with nonzero and then zeroed divisors, which separates the gated case from the ungated one.

// File: rtl/duo_regs_pkg.sv
package duo_regs_pkg;
  localparam int CHANS  = 2;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_LOW  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_HIGH = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_ALT  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_LINE = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_ID   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_REV  = 3'd5;

  typedef enum logic [1:0] {
    MF_OP2  = 2'b00,
    MF_BAUD = 2'b01,
    MF_NONE = 2'b10,
    MF_RXR  = 2'b11
  } mfSel_e;

  typedef struct packed {
    logic [CHANS-1:0]  chWe;
    logic              bankSel;
    logic              altWe;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wrStrobe_t;
endpackage

// File: rtl/duo_regs_ctrl.sv
module duo_regs_ctrl
  import duo_regs_pkg::*;
(
  input  logic              busCs,
  input  logic              busChan,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [CHANS-1:0]  lcrBank,
  input  logic              concEn,
  output wrStrobe_t         strobe
);
  logic wrHit;
  logic bankEff;

  always_comb begin
    wrHit   = busCs & busWr;
    bankEff = concEn ? lcrBank[0] : lcrBank[busChan];
    strobe  = '0;
    strobe.addr    = busAddr;
    strobe.data    = busWrData;
    strobe.bankSel = bankEff;
    if (wrHit) begin
      if (concEn) strobe.chWe = '1;
      else        strobe.chWe[busChan] = 1'b1;
      strobe.altWe = (busAddr == ADDR_ALT) && bankEff;
    end
  end
endmodule

// File: rtl/duo_regs_dp.sv
module duo_regs_dp
  import duo_regs_pkg::*;
#(
  parameter logic [DATA_W-1:0] ID_BYTE  = 8'h02,
  parameter logic [DATA_W-1:0] REV_BYTE = 8'h01,
  parameter int                SEL_W    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic              busCs,
  input  logic              busRd,
  input  logic              busChan,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CHANS-1:0]  op2N,
  input  logic [CHANS-1:0]  baudN,
  input  logic [CHANS-1:0]  rxRdyN,
  output logic [CHANS-1:0]  lcrBank,
  output logic              concEn,
  output logic [DATA_W-1:0] busRdData,
  output logic [CHANS-1:0]  mfN
);
  localparam int ALT_W = SEL_W + 1;

  logic [CHANS-1:0][DATA_W-1:0] lcrQ, divLoQ, divHiQ, dataQ, ierQ;
  logic [ALT_W-1:0] altQ;
  logic [SEL_W-1:0] mfSel;

  // shared alternate function byte: only the low bits are stored
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             altQ <= '0;
    else if (strobe.altWe) altQ <= strobe.data[ALT_W-1:0];
  end

  assign concEn = altQ[0];
  assign mfSel  = altQ[ALT_W-1:1];

  for (genvar ch = 0; ch < CHANS; ch++) begin : g_chan
    logic we;
    assign we = strobe.chWe[ch];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lcrQ[ch]   <= '0;
        divLoQ[ch] <= '0;
        divHiQ[ch] <= '0;
        dataQ[ch]  <= '0;
        ierQ[ch]   <= '0;
      end else if (we) begin
        unique case (strobe.addr)
          ADDR_LOW:  if (strobe.bankSel) divLoQ[ch] <= strobe.data;
                     else                dataQ[ch]  <= strobe.data;
          ADDR_HIGH: if (strobe.bankSel) divHiQ[ch] <= strobe.data;
                     else                ierQ[ch]   <= strobe.data;
          ADDR_LINE: lcrQ[ch] <= strobe.data;
          default: ;
        endcase
      end
    end
    assign lcrBank[ch] = lcrQ[ch][DATA_W-1];

    always_comb begin
      unique case (mfSel_e'(mfSel))
        MF_OP2:  mfN[ch] = op2N[ch];
        MF_BAUD: mfN[ch] = baudN[ch];
        MF_RXR:  mfN[ch] = rxRdyN[ch];
        default: mfN[ch] = 1'b1;
      endcase
    end
  end

  logic rdBank;
  logic divZero;
  always_comb begin
    rdBank    = lcrBank[busChan];
    divZero   = (divLoQ[busChan] == '0) && (divHiQ[busChan] == '0);
    busRdData = '0;
    if (busCs && busRd) begin
      unique case (busAddr)
        ADDR_LOW:  busRdData = rdBank ? divLoQ[busChan] : dataQ[busChan];
        ADDR_HIGH: busRdData = rdBank ? divHiQ[busChan] : ierQ[busChan];
        ADDR_ALT:  if (rdBank) busRdData = {{(DATA_W-ALT_W){1'b0}}, altQ};
        ADDR_LINE: busRdData = lcrQ[busChan];
        ADDR_ID:   if (rdBank && divZero) busRdData = ID_BYTE;
        ADDR_REV:  if (rdBank && divZero) busRdData = REV_BYTE;
        default: ;
      endcase
    end
  end

  // R3
  conc_both_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.chWe == 2'b11 && strobe.addr == ADDR_LINE) |=> (lcrQ[0] == lcrQ[1]));
  // R2
  single_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.chWe == 2'b01) |=> ($stable(lcrQ[1]) && $stable(dataQ[1]) && $stable(ierQ[1])));
  // R9
  alt_rsv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busCs && busRd && busAddr == ADDR_ALT) |-> (busRdData[DATA_W-1:ALT_W] == '0));
  // R10
  id_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busCs && busRd && busAddr == ADDR_ID && !divZero) |-> (busRdData == '0));
  // R8
  mf_rsv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mfSel == MF_NONE) |-> (mfN == '1));
  // R7
  mf_rxr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mfSel == MF_RXR) |-> (mfN == rxRdyN));
endmodule

// File: rtl/duo_uart_regs.sv
module duo_uart_regs
  import duo_regs_pkg::*;
#(
  parameter logic [7:0] ID_BYTE  = 8'h02,
  parameter logic [7:0] REV_BYTE = 8'h01
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busCs,
  input  logic       busChan,
  input  logic [2:0] busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busWrData,
  output logic [7:0] busRdData,
  input  logic [1:0] op2N,
  input  logic [1:0] baudN,
  input  logic [1:0] rxRdyN,
  output logic [1:0] mfN
);
  wrStrobe_t        strobe;
  logic [CHANS-1:0] lcrBank;
  logic             concEn;

  duo_regs_ctrl u_ctrl (
    .busCs, .busChan, .busWr, .busAddr, .busWrData,
    .lcrBank, .concEn, .strobe
  );

  duo_regs_dp #(.ID_BYTE(ID_BYTE), .REV_BYTE(REV_BYTE)) u_dp (
    .clk, .rstN, .strobe, .busCs, .busRd, .busChan, .busAddr,
    .op2N, .baudN, .rxRdyN, .lcrBank, .concEn, .busRdData, .mfN
  );
endmodule

// File: tb/duo_uart_regs_bench.sv
module duo_uart_regs_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busCs = 1'b0, busChan = 1'b0, busWr = 1'b0, busRd = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [1:0] op2N = 2'b01, baudN = 2'b10, rxRdyN = 2'b00;
  logic [1:0] mfN;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] exp; string tag; } item_t;
  item_t expQ[$];

  always #2 clk = ~clk;

  duo_uart_regs u_duo_uart_regs (.*);

  task automatic wrReg(input logic ch, input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    busCs = 1; busWr = 1; busChan = ch; busAddr = a; busWrData = d;
    @(posedge clk); #1;
    busCs = 0; busWr = 0;
  endtask

  task automatic rdReg(input logic ch, input logic [2:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    expQ.push_back('{exp: e, tag: tag});
    busCs = 1; busRd = 1; busChan = ch; busAddr = a;
    @(posedge clk); #1;
    busCs = 0; busRd = 0;
  endtask

  task automatic chkMf(input logic [1:0] e, input string tag);
    @(negedge clk);
    vectors++;
    if (mfN !== e) begin
      fails++;
      $display("FAIL %s mfN actual=%b expected=%b", tag, mfN, e);
    end
  endtask

  // monitor: pops expected read data as each read completes
  always @(negedge clk) begin
    if (busCs && busRd) begin
      item_t it;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL monitor unexpected read actual=%h expected=none", busRdData);
      end else begin
        it = expQ.pop_front();
        vectors++;
        if (busRdData !== it.exp) begin
          fails++;
          $display("FAIL %s read actual=%h expected=%h", it.tag, busRdData, it.exp);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R1 reset values and default pin source
    rdReg(0, 3'd3, 8'h00, "R1 lcr A");
    rdReg(1, 3'd0, 8'h00, "R1 data B");
    chkMf(2'b01, "R1/R7 op2 default");
    // R2 single-channel write
    wrReg(0, 3'd1, 8'h5A);
    rdReg(0, 3'd1, 8'h5A, "R2/R4 ier A written");
    rdReg(1, 3'd1, 8'h00, "R2/R4 ier B untouched");
    // R5 shared byte via A, concurrent on
    wrReg(0, 3'd3, 8'h80);
    wrReg(0, 3'd2, 8'h01);
    rdReg(1, 3'd2, 8'h00, "R5 alt hidden in bank0 B");
    wrReg(1, 3'd3, 8'h80);             // concurrent: both lcr
    rdReg(0, 3'd3, 8'h80, "R3 lcr A via concurrent");
    rdReg(1, 3'd2, 8'h01, "R5 alt seen via B");
    wrReg(1, 3'd0, 8'h33);
    rdReg(0, 3'd0, 8'h33, "R3/R4 divLo A");
    rdReg(1, 3'd0, 8'h33, "R3/R4 divLo B");
    // R6 banking from channel A
    wrReg(1, 3'd2, 8'h00);             // off, written through B
    rdReg(0, 3'd2, 8'h00, "R5 alt cleared via B");
    wrReg(1, 3'd3, 8'h03);             // B bank 0, A stays bank 1
    wrReg(0, 3'd2, 8'h01);             // on
    wrReg(1, 3'd1, 8'h44);             // bank from A -> divHi both
    rdReg(0, 3'd1, 8'h44, "R6 divHi A");
    rdReg(1, 3'd1, 8'h00, "R6/R4 ier B not written");
    rdReg(1, 3'd3, 8'h03, "R4 lcr B follows select");
    wrReg(0, 3'd2, 8'h00);             // off
    wrReg(1, 3'd3, 8'h80);
    rdReg(1, 3'd1, 8'h44, "R6 divHi B");
    rdReg(0, 3'd3, 8'h80, "R2 lcr A unchanged");
    // R9 and R7/R8 pin selection
    wrReg(0, 3'd2, 8'hFE);
    rdReg(1, 3'd2, 8'h06, "R9 reserved bits zero");
    chkMf(2'b00, "R7 rxrdy source");
    wrReg(0, 3'd2, 8'h02);
    chkMf(2'b10, "R7 baud source");
    wrReg(0, 3'd2, 8'h04);
    chkMf(2'b11, "R8 reserved code high");
    wrReg(0, 3'd2, 8'h00);
    chkMf(2'b01, "R7 op2 source");
    // R10 identification gating
    rdReg(0, 3'd4, 8'h00, "R10 id gated");
    wrReg(0, 3'd0, 8'h00);
    rdReg(0, 3'd4, 8'h00, "R10 id gated by high byte");
    wrReg(0, 3'd1, 8'h00);
    rdReg(0, 3'd4, 8'h02, "R10 id byte");
    rdReg(0, 3'd5, 8'h01, "R10 rev byte");
    rdReg(1, 3'd5, 8'h00, "R10 B divisors nonzero");
    repeat (2) @(posedge clk);
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL scoreboard pending actual=%0d expected=0", expQ.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule